// File: doc/BRIEF.md
# Guard Predicate Register File

This block holds the one-bit guard predicates of a statically scheduled machine that issues several operations in each wide instruction word. Every operation slot names one guard predicate. The block answers with a run/squash bit for each slot. A slot whose guard reads 1 runs normally. A slot whose guard reads 0 is nullified, so the pipeline turns it into a no-op.

Predicates change only through three define operations: set-from-boolean, set-from-inverted-boolean and loop-branch. Any slot may carry one of them, and each is guarded by a source predicate of its own. The loop-branch operation compares a shared iteration counter with a shared bound. Its result is the predicate that enables the next iteration.

Register 0 is the always-true guard. Guard reads are combinational from the stored state, so a read sees the value committed by the previous word. Define writes become visible from the next word on.

Top module: `guard_pred_file`

## Requirements
- R1: The file holds NUM_PRED (default 128) one-bit predicates. Each of NUM_SLOTS (default 7) slots has a guard index at `guard_idx[s*7 +: 7]`. `run_ok[s]` is 1 when the named predicate reads 1 and 0 when it reads 0.
- R2: Predicate 0 always reads 1. A define aimed at destination 0 has no effect.
- R3: A synchronous reset (`rst` high at a clock edge) clears predicates 1 to NUM_PRED-1 to 0.
- R4: A define of kind 0 (set) whose source guard reads 1 writes `def_bool[s]` into its destination at the clock edge.
- R5: A define of kind 1 (inverted set) whose source guard reads 1 writes the complement of `def_bool[s]` into its destination.
- R6: A define of kind 2 (loop-branch) whose source guard reads 1 writes 1 when `loop_count < loop_bound` (unsigned) and 0 otherwise. Equal values give 0.
- R7: A define whose source guard reads 0 is squashed, and its destination keeps its value.
- R8: Kind 3 writes nothing, and a slot with `def_valid[s]` low writes nothing. Without a define, the predicates hold their values.
- R9: When several slots in one word write the same destination, the highest-numbered slot that is not squashed decides the value.
- R10: A guard read in the same word as a write to that predicate returns the value from before the write.
- Field positions: `def_kind[s*2 +: 2]`, `def_src[s*7 +: 7]` and `def_dst[s*7 +: 7]` for slot s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| guard_idx | input | NUM_SLOTS*7 | Guard predicate index for each slot |
| run_ok | output | NUM_SLOTS | 1 = slot runs, 0 = slot squashed |
| def_valid | input | NUM_SLOTS | Slot carries a define operation |
| def_kind | input | NUM_SLOTS*2 | Define kind: 0 set, 1 inverted set, 2 loop-branch, 3 none |
| def_src | input | NUM_SLOTS*7 | Source guard index of each define |
| def_dst | input | NUM_SLOTS*7 | Destination predicate of each define |
| def_bool | input | NUM_SLOTS | Boolean operand of set and inverted set |
| loop_count | input | CNT_W | Loop iteration counter |
| loop_bound | input | CNT_W | Loop bound |

## Verification
Two things can meet in one word, and both are checked. First, a guard read can target a predicate that a define of the same word is writing. The bench issues the write and the read together and expects the old value. It expects the new value one word later. Second, two or more slots can aim defines at the same destination. The bench puts a set and a contrary set in a low and a high slot. It also places a squashed high slot above a live low slot, to confirm that only a non-squashed writer decides. A random phase then mixes overlapping destinations and guards drawn from the same small range, and the reference model resolves each word from the state of the word before.

// File: rtl/guard_pred_pkg.sv
package guard_pred_pkg;
   typedef enum logic [1:0] {
      DEF_SET     = 2'd0,
      DEF_SET_INV = 2'd1,
      DEF_LOOP    = 2'd2,
      DEF_NONE    = 2'd3
   } def_kind_e;

   function automatic logic def_value(input def_kind_e kind, input logic bval,
                                      input logic loop_go);
      logic v;
      case (kind)
         DEF_SET:     v = bval;
         DEF_SET_INV: v = ~bval;
         default:     v = loop_go;
      endcase
      return v;
   endfunction
endpackage

// File: rtl/pred_slot_decode.sv
module pred_slot_decode
   import guard_pred_pkg::*;
#(
   parameter int NUM_PRED = 128,
   localparam int IDX_W = $clog2(NUM_PRED)
) (
   input  logic                valid,
   input  logic [1:0]          kind,
   input  logic [IDX_W-1:0]    src,
   input  logic [IDX_W-1:0]    dst,
   input  logic                bval,
   input  logic                loop_go,
   input  logic [NUM_PRED-1:0] cur_bits,
   output logic                wr_en,
   output logic [IDX_W-1:0]    wr_idx,
   output logic                wr_val
);
   def_kind_e kind_e;
   logic      guard_ok;
   logic      dst_live;

   always_comb begin
      kind_e   = def_kind_e'(kind);
      guard_ok = cur_bits[src];
      dst_live = (dst != '0);
      wr_en    = valid && (kind_e != DEF_NONE) && guard_ok && dst_live;
      wr_idx   = dst;
      wr_val   = def_value(kind_e, bval, loop_go);
   end
endmodule

// File: rtl/pred_write_merge.sv
module pred_write_merge #(
   parameter int NUM_PRED  = 128,
   parameter int NUM_SLOTS = 7,
   localparam int IDX_W = $clog2(NUM_PRED)
) (
   input  logic [NUM_SLOTS-1:0]       slot_en,
   input  logic [NUM_SLOTS*IDX_W-1:0] slot_idx,
   input  logic [NUM_SLOTS-1:0]       slot_val,
   output logic [NUM_PRED-1:1]        reg_we,
   output logic [NUM_PRED-1:1]        reg_val
);
   for (genvar r = 1; r < NUM_PRED; r++) begin : g_reg
      logic hit;
      logic val;
      always_comb begin
         hit = 1'b0;
         val = 1'b0;
         for (int s = 0; s < NUM_SLOTS; s++) begin
            if (slot_en[s] && (slot_idx[s*IDX_W +: IDX_W] == IDX_W'(r))) begin
               hit = 1'b1;
               val = slot_val[s];
            end
         end
      end
      assign reg_we[r]  = hit;
      assign reg_val[r] = val;
   end
endmodule

// File: rtl/pred_storage.sv
module pred_storage #(
   parameter int NUM_PRED = 128
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [NUM_PRED-1:1] reg_we,
   input  logic [NUM_PRED-1:1] reg_val,
   output logic [NUM_PRED-1:0] bits
);
   logic [NUM_PRED-1:1] store_q;

   for (genvar r = 1; r < NUM_PRED; r++) begin : g_cell
      always_ff @(posedge clk) begin
         if (rst)
            store_q[r] <= 1'b0;
         else if (reg_we[r])
            store_q[r] <= reg_val[r];
      end
   end

   assign bits = {store_q, 1'b1};
endmodule

// File: rtl/pred_guard_read.sv
module pred_guard_read #(
   parameter int NUM_PRED  = 128,
   parameter int NUM_SLOTS = 7,
   localparam int IDX_W = $clog2(NUM_PRED)
) (
   input  logic [NUM_PRED-1:0]        bits,
   input  logic [NUM_SLOTS*IDX_W-1:0] guard_idx,
   output logic [NUM_SLOTS-1:0]       run_ok
);
   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_port
      assign run_ok[s] = bits[guard_idx[s*IDX_W +: IDX_W]];
   end
endmodule

// File: rtl/guard_pred_file.sv
module guard_pred_file #(
   parameter int NUM_PRED  = 128,
   parameter int NUM_SLOTS = 7,
   parameter int CNT_W     = 16,
   localparam int IDX_W = $clog2(NUM_PRED)
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [NUM_SLOTS*IDX_W-1:0] guard_idx,
   output logic [NUM_SLOTS-1:0]       run_ok,
   input  logic [NUM_SLOTS-1:0]       def_valid,
   input  logic [NUM_SLOTS*2-1:0]     def_kind,
   input  logic [NUM_SLOTS*IDX_W-1:0] def_src,
   input  logic [NUM_SLOTS*IDX_W-1:0] def_dst,
   input  logic [NUM_SLOTS-1:0]       def_bool,
   input  logic [CNT_W-1:0]           loop_count,
   input  logic [CNT_W-1:0]           loop_bound
);
   if (NUM_PRED < 2 || (1 << IDX_W) != NUM_PRED) begin : g_bad_pred
      $error("NUM_PRED must be a power of two of at least 2");
   end
   if (NUM_SLOTS < 1) begin : g_bad_slots
      $error("NUM_SLOTS must be at least 1");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end

   logic [NUM_PRED-1:0]        pred_bits;
   logic                       loop_go;
   logic [NUM_SLOTS-1:0]       slot_en;
   logic [NUM_SLOTS*IDX_W-1:0] slot_idx;
   logic [NUM_SLOTS-1:0]       slot_val;
   logic [NUM_PRED-1:1]        reg_we;
   logic [NUM_PRED-1:1]        reg_val;

   assign loop_go = (loop_count < loop_bound);

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      pred_slot_decode #(.NUM_PRED(NUM_PRED)) u_dec (
         .valid    (def_valid[s]),
         .kind     (def_kind[s*2 +: 2]),
         .src      (def_src[s*IDX_W +: IDX_W]),
         .dst      (def_dst[s*IDX_W +: IDX_W]),
         .bval     (def_bool[s]),
         .loop_go  (loop_go),
         .cur_bits (pred_bits),
         .wr_en    (slot_en[s]),
         .wr_idx   (slot_idx[s*IDX_W +: IDX_W]),
         .wr_val   (slot_val[s])
      );
   end

   pred_write_merge #(.NUM_PRED(NUM_PRED), .NUM_SLOTS(NUM_SLOTS)) u_merge (
      .slot_en  (slot_en),
      .slot_idx (slot_idx),
      .slot_val (slot_val),
      .reg_we   (reg_we),
      .reg_val  (reg_val)
   );

   pred_storage #(.NUM_PRED(NUM_PRED)) u_store (
      .clk     (clk),
      .rst     (rst),
      .reg_we  (reg_we),
      .reg_val (reg_val),
      .bits    (pred_bits)
   );

   pred_guard_read #(.NUM_PRED(NUM_PRED), .NUM_SLOTS(NUM_SLOTS)) u_read (
      .bits      (pred_bits),
      .guard_idx (guard_idx),
      .run_ok    (run_ok)
   );
endmodule

// File: rtl/guard_pred_file_chk.sv
module guard_pred_file_chk #(
   parameter int NUM_PRED  = 128,
   parameter int NUM_SLOTS = 7,
   parameter int CNT_W     = 16,
   localparam int IDX_W = $clog2(NUM_PRED)
) (
   input logic                       clk,
   input logic                       rst,
   input logic [NUM_SLOTS*IDX_W-1:0] guard_idx,
   input logic [NUM_SLOTS-1:0]       run_ok,
   input logic [NUM_SLOTS-1:0]       def_valid,
   input logic [NUM_SLOTS*2-1:0]     def_kind,
   input logic [NUM_SLOTS*IDX_W-1:0] def_src,
   input logic [NUM_SLOTS*IDX_W-1:0] def_dst,
   input logic [NUM_SLOTS-1:0]       def_bool,
   input logic [CNT_W-1:0]           loop_count,
   input logic [CNT_W-1:0]           loop_bound,
   input logic [NUM_PRED-1:0]        pred_bits
);
   // R3
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (pred_bits[NUM_PRED-1:1] == '0));

   // R8
   idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
      (def_valid == '0) |=> $stable(pred_bits));

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_chk
      logic [IDX_W-1:0] src_s;
      logic [IDX_W-1:0] dst_s;
      logic [1:0]       kind_s;
      logic             higher_busy;
      logic             lands;
      logic             alone;

      always_comb begin
         src_s  = def_src[s*IDX_W +: IDX_W];
         dst_s  = def_dst[s*IDX_W +: IDX_W];
         kind_s = def_kind[s*2 +: 2];
         higher_busy = 1'b0;
         for (int h = s + 1; h < NUM_SLOTS; h++)
            higher_busy = higher_busy | def_valid[h];
         alone = (def_valid == NUM_SLOTS'(1) << s);
         lands = def_valid[s] && !higher_busy && pred_bits[src_s] && (dst_s != '0);
      end

      // R2
      zero_guard_chk: assert property (@(posedge clk) disable iff (rst)
         (guard_idx[s*IDX_W +: IDX_W] == '0) |-> run_ok[s]);

      // R4 R9
      set_write_chk: assert property (@(posedge clk) disable iff (rst)
         (lands && kind_s == 2'd0) |=> (pred_bits[$past(dst_s)] == $past(def_bool[s])));

      // R5 R9
      inv_write_chk: assert property (@(posedge clk) disable iff (rst)
         (lands && kind_s == 2'd1) |=> (pred_bits[$past(dst_s)] == !$past(def_bool[s])));

      // R6 R9
      loop_write_chk: assert property (@(posedge clk) disable iff (rst)
         (lands && kind_s == 2'd2) |=>
            (pred_bits[$past(dst_s)] == ($past(loop_count) < $past(loop_bound))));

      // R7
      squash_chk: assert property (@(posedge clk) disable iff (rst)
         (alone && !pred_bits[src_s]) |=> $stable(pred_bits));
   end
endmodule

bind guard_pred_file guard_pred_file_chk #(
   .NUM_PRED(NUM_PRED), .NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .guard_idx  (guard_idx),
   .run_ok     (run_ok),
   .def_valid  (def_valid),
   .def_kind   (def_kind),
   .def_src    (def_src),
   .def_dst    (def_dst),
   .def_bool   (def_bool),
   .loop_count (loop_count),
   .loop_bound (loop_bound),
   .pred_bits  (pred_bits)
);

// File: tb/guard_pred_file_test.sv
`timescale 1ns/100ps
module guard_pred_file_test;
   localparam int NP = 128;
   localparam int NS = 7;
   localparam int IW = 7;
   localparam int CW = 16;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [NS*IW-1:0] guard_idx = '0;
   logic [NS-1:0]    run_ok;
   logic [NS-1:0]    def_valid = '0;
   logic [NS*2-1:0]  def_kind = '0;
   logic [NS*IW-1:0] def_src = '0;
   logic [NS*IW-1:0] def_dst = '0;
   logic [NS-1:0]    def_bool = '0;
   logic [CW-1:0]    loop_count = '0;
   logic [CW-1:0]    loop_bound = '0;

   always #2.5 clk = ~clk;

   guard_pred_file uut (
      .clk(clk), .rst(rst), .guard_idx(guard_idx), .run_ok(run_ok),
      .def_valid(def_valid), .def_kind(def_kind), .def_src(def_src),
      .def_dst(def_dst), .def_bool(def_bool),
      .loop_count(loop_count), .loop_bound(loop_bound)
   );

   typedef struct {
      int    stamp;
      int    slot;
      logic  exp;
      string tag;
   } item_t;

   item_t     sb[$];
   int        cyc = 0;
   int        total = 0;
   int        bad = 0;
   bit        done = 1'b0;
   logic [NP-1:0] mdl;

   logic       b_valid [NS];
   logic [1:0] b_kind  [NS];
   logic [6:0] b_src   [NS];
   logic [6:0] b_dst   [NS];
   logic       b_bool  [NS];
   logic [6:0] b_rd    [NS];
   string      b_tag   [NS];
   logic [CW-1:0] b_cnt, b_bnd;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic clear_ops();
      for (int s = 0; s < NS; s++) begin
         b_valid[s] = 1'b0; b_kind[s] = 2'd3; b_src[s] = '0;
         b_dst[s] = '0; b_bool[s] = 1'b0; b_rd[s] = '0; b_tag[s] = "R2";
      end
      b_cnt = '0; b_bnd = '0;
   endtask

   task automatic op(input int s, input logic [1:0] k, input int src,
                     input int dst, input logic bv);
      b_valid[s] = 1'b1; b_kind[s] = k; b_src[s] = 7'(src);
      b_dst[s] = 7'(dst); b_bool[s] = bv;
   endtask

   task automatic rd(input int s, input int idx, input string tag);
      b_rd[s] = 7'(idx);
      b_tag[s] = (idx == 0) ? "R2" : tag;
   endtask

   // driver: apply one word, queue expected reads, advance the model
   task automatic step();
      logic [NP-1:0] old;
      item_t it;
      @(negedge clk);
      for (int s = 0; s < NS; s++) begin
         guard_idx[s*IW +: IW] = b_rd[s];
         def_valid[s]          = b_valid[s];
         def_kind[s*2 +: 2]    = b_kind[s];
         def_src[s*IW +: IW]   = b_src[s];
         def_dst[s*IW +: IW]   = b_dst[s];
         def_bool[s]           = b_bool[s];
      end
      loop_count = b_cnt;
      loop_bound = b_bnd;
      for (int s = 0; s < NS; s++) begin
         it.stamp = cyc; it.slot = s; it.exp = mdl[b_rd[s]]; it.tag = b_tag[s];
         sb.push_back(it);
      end
      old = mdl;
      for (int s = 0; s < NS; s++) begin
         if (b_valid[s] && b_kind[s] != 2'd3 && old[b_src[s]] && b_dst[s] != 0) begin
            case (b_kind[s])
               2'd0:    mdl[b_dst[s]] = b_bool[s];
               2'd1:    mdl[b_dst[s]] = !b_bool[s];
               default: mdl[b_dst[s]] = (b_cnt < b_bnd);
            endcase
         end
      end
   endtask

   task automatic do_reset();
      clear_ops();
      @(negedge clk);
      rst = 1'b1;
      def_valid = '0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      mdl = '0;
      mdl[0] = 1'b1;
   endtask

   // monitor: compare queued expectations away from the clock edge
   initial begin
      item_t it;
      forever begin
         @(negedge clk);
         #1;
         while (sb.size() > 0 && sb[0].stamp == cyc) begin
            it = sb.pop_front();
            total++;
            if (run_ok[it.slot] !== it.exp) begin
               bad++;
               $display("FAIL %s slot %0d: actual=%b expected=%b",
                        it.tag, it.slot, run_ok[it.slot], it.exp);
            end
         end
      end
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      mdl = '0;
      mdl[0] = 1'b1;
      do_reset();

      // R3 reset state, R2 for predicate 0
      clear_ops();
      rd(0, 0, "R2"); rd(1, 1, "R3"); rd(2, 2, "R3"); rd(3, 50, "R3");
      rd(4, 64, "R3"); rd(5, 100, "R3"); rd(6, 127, "R3");
      step();

      // R10: read of 5 in the word that writes it
      clear_ops();
      op(0, 2'd0, 0, 5, 1'b1); op(3, 2'd0, 0, 20, 1'b1);
      op(4, 2'd0, 0, 9, 1'b1); op(5, 2'd0, 0, 10, 1'b1);
      op(1, 2'd1, 0, 6, 1'b0);
      rd(0, 5, "R10"); rd(1, 20, "R10"); rd(2, 6, "R10");
      step();

      // R4 and R5 results, then a loop-branch with 3 < 5
      clear_ops();
      rd(0, 5, "R4"); rd(1, 20, "R4"); rd(2, 6, "R5"); rd(3, 9, "R4");
      rd(4, 10, "R4"); rd(5, 1, "R1"); rd(6, 0, "R2");
      op(0, 2'd2, 0, 8, 1'b0); op(1, 2'd1, 0, 20, 1'b1);
      b_cnt = 16'd3; b_bnd = 16'd5;
      step();

      // R6 equal case
      clear_ops();
      rd(0, 8, "R6"); rd(1, 20, "R5");
      op(2, 2'd2, 0, 9, 1'b1);
      b_cnt = 16'd5; b_bnd = 16'd5;
      step();

      // R6 greater case
      clear_ops();
      rd(0, 9, "R6");
      op(3, 2'd2, 0, 10, 1'b1);
      b_cnt = 16'd6; b_bnd = 16'd5;
      step();

      // R7 squash, R4 guarded by a non-zero predicate, R2 write to 0
      clear_ops();
      rd(0, 10, "R6");
      op(0, 2'd0, 1, 5, 1'b0); op(2, 2'd1, 9, 6, 1'b1);
      op(4, 2'd0, 5, 11, 1'b1); op(5, 2'd0, 0, 0, 1'b0);
      op(6, 2'd2, 20, 21, 1'b0);
      b_cnt = 16'd0; b_bnd = 16'd9;
      step();

      // R8 kind 3 and an invalid slot
      clear_ops();
      rd(0, 5, "R7"); rd(1, 6, "R7"); rd(2, 11, "R4"); rd(3, 0, "R2");
      rd(4, 21, "R7");
      op(0, 2'd3, 0, 12, 1'b1); op(1, 2'd0, 0, 13, 1'b1);
      b_valid[1] = 1'b0;
      step();

      // R9 collisions: higher slot wins; squashed higher slot does not
      clear_ops();
      rd(0, 12, "R8"); rd(1, 13, "R8");
      op(1, 2'd0, 0, 14, 1'b1); op(4, 2'd0, 0, 14, 1'b0);
      op(2, 2'd0, 0, 15, 1'b1); op(6, 2'd0, 1, 15, 1'b0);
      op(0, 2'd0, 0, 16, 1'b0); op(5, 2'd0, 0, 16, 1'b1);
      step();

      clear_ops();
      rd(0, 14, "R9"); rd(1, 15, "R9"); rd(2, 16, "R9");
      step();

      // R1 mixed traffic over a small predicate range
      for (int n = 0; n < 120; n++) begin
         clear_ops();
         for (int s = 0; s < NS; s++) begin
            rd(s, int'($urandom_range(0, 15)), "R1");
            if ($urandom_range(0, 2) != 0)
               op(s, 2'($urandom_range(0, 3)), int'($urandom_range(0, 15)),
                  int'($urandom_range(0, 15)), 1'($urandom_range(0, 1)));
         end
         b_cnt = 16'($urandom_range(0, 7));
         b_bnd = 16'($urandom_range(0, 7));
         step();
      end

      // R3 reset in mid-run
      do_reset();
      clear_ops();
      for (int s = 0; s < NS; s++) rd(s, s * 2 + 1, "R3");
      rd(6, 0, "R2");
      step();
      clear_ops();
      for (int s = 0; s < NS; s++) rd(s, s * 2 + 2, "R3");
      step();

      @(negedge clk);
      #2;
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule